// File: doc/BRIEF.md
# Pipelined Phase-to-Quadrature Sinusoid Generator

This block turns a phase word into a point on the unit circle. The phase arrives on an AXI4-Stream slave port. It is a fraction of one full turn. The block returns the sine and the cosine of that angle as a packed quadrature pair on an AXI4-Stream master port. Each input beat also carries a last flag and a one-bit user flag. Both flags travel through the pipeline with their own sample and come out on the output beat that the sample produces.

The datapath uses quarter-wave symmetry. The top two phase bits choose the quadrant. The next bits address a table that is computed at elaboration and holds one rounded quarter period of the sine. Cosine is read from the mirrored table address, which is the same as a quarter-turn shift. Phase bits below the table address are dropped.

The pipeline moves forward only when a new input beat is accepted. A result therefore stays inside the block until two more inputs push it out. Any flushing is left to the logic around the block.

Top module: `phase_quad_gen`

## Requirements
- R1: The phase word is an unsigned fraction of one turn. The whole input range spans [0, 1.0). Bits 23:22 select the quadrant (0 covers [0, 1/4), 1 covers [1/4, 1/2), and so on). Bits 21:12 select the step inside the quadrant. Bits 11:0 are ignored, so the output follows the phase truncated to its top 12 bits.
- R2: Each output component is a 16-bit two's-complement value with 14 fractional bits. It lies within 2 LSB of 16384 times the ideal sine or cosine of the truncated phase, and never outside [-16384, 16384].
- R3: The output word carries the sine in bits 31:16 and the cosine in bits 15:0.
- R4: The last and user flags of an output beat are equal to the flags of the input beat whose phase produced it.
- R5: The result of the n-th accepted input becomes valid in the cycle after the (n+2)-th input is accepted. In a cycle with no accepted input, no new valid beat appears and the output word does not change.
- R6: Input ready is low exactly when a valid output beat is waiting and the output side is not ready. A waiting beat stays valid with unchanged word and flags until it is taken.
- R7: Reset is synchronous and active low, and is held for at least 2 cycles. During reset and in the first cycle after it, the output is not valid. Samples that were in flight before reset never appear.
- R8: Phases of exactly 0, 1/4, 1/2 and 3/4 turn give (cosine, sine) of (16384, 0), (0, 16384), (-16384, 0) and (0, -16384) with no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ph_tdata | input | 24 | Phase as an unsigned fraction of a turn |
| ph_tvalid | input | 1 | Phase beat valid |
| ph_tlast | input | 1 | Last flag of the phase beat |
| ph_tuser | input | 1 | User flag of the phase beat |
| ph_tready | output | 1 | Phase beat can be accepted |
| iq_tdata | output | 32 | Sine in bits 31:16, cosine in bits 15:0 |
| iq_tvalid | output | 1 | Output beat valid |
| iq_tlast | output | 1 | Last flag carried from the input |
| iq_tuser | output | 1 | User flag carried from the input |
| iq_tready | input | 1 | Output side accepts the beat |

## Verification
Phases at the four quadrant boundaries check the folding signs and the exact unit values. Phases with low bits set show whether truncation is applied rather than rounding. A long run of random phases, flags, gaps and backpressure is compared every cycle with a queue model. It tells apart a wrong latency, a lost or duplicated beat, swapped halves and sideband slips. Stopping the input with beats in flight, and a reset in the middle of a burst, show that results stay inside the block and that reset discards them.

// File: rtl/qsg_pkg.sv
`timescale 1ns/1ps
package qsg_pkg;

    typedef enum logic [1:0] {QD_0 = 2'd0, QD_1 = 2'd1, QD_2 = 2'd2, QD_3 = 2'd3} quad_e;

    typedef struct packed {
        logic last;
        logic user;
    } side_t;

    // Sine of (pi/2)*j/2^addr_w scaled by 2^frac_w, rounded and clamped.
    // Fixed-point Taylor series with a 2^30 scale, evaluated at elaboration.
    function automatic int quarter_sine(int j, int addr_w, int frac_w, int max_code);
        longint x;
        longint x2;
        longint term;
        longint acc;
        longint val;
        x    = (64'sd3373259426 * longint'(j)) >>> (addr_w + 1);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 7; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        val = (acc * (64'sd1 <<< frac_w) + (64'sd1 <<< 29)) >>> 30;
        if (val > longint'(max_code)) val = longint'(max_code);
        if (val < 0) val = 0;
        return int'(val);
    endfunction

endpackage

// File: rtl/qsg_qtr_rom.sv
`timescale 1ns/1ps
module qsg_qtr_rom #(
    parameter int ADDR_W = 10,
    parameter int SMP_W  = 16,
    parameter int FRAC_W = 14
) (
    input  logic [ADDR_W:0]   addr_a,
    input  logic [ADDR_W:0]   addr_b,
    output logic [SMP_W-1:0]  data_a,
    output logic [SMP_W-1:0]  data_b
);
    localparam int TAB_N    = (1 << ADDR_W) + 1;
    localparam int MAX_CODE = (1 << (SMP_W - 1)) - 1;

    logic [SMP_W-1:0] tab [TAB_N];

    for (genvar j = 0; j < TAB_N; j++) begin : g_tab
        localparam int CODE = qsg_pkg::quarter_sine(j, ADDR_W, FRAC_W, MAX_CODE);
        assign tab[j] = SMP_W'(CODE);
    end

    assign data_a = tab[addr_a];
    assign data_b = tab[addr_b];
endmodule

// File: rtl/qsg_fold.sv
`timescale 1ns/1ps
module qsg_fold #(
    parameter int SMP_W = 16
) (
    input  qsg_pkg::quad_e           quad,
    input  logic [SMP_W-1:0]         mag_dir,
    input  logic [SMP_W-1:0]         mag_mir,
    output logic signed [SMP_W-1:0]  sin_o,
    output logic signed [SMP_W-1:0]  cos_o
);
    logic signed [SMP_W-1:0] pos_dir;
    logic signed [SMP_W-1:0] pos_mir;

    assign pos_dir = $signed(mag_dir);
    assign pos_mir = $signed(mag_mir);

    always_comb begin
        unique case (quad)
            qsg_pkg::QD_0: begin sin_o =  pos_dir; cos_o =  pos_mir; end
            qsg_pkg::QD_1: begin sin_o =  pos_mir; cos_o = -pos_dir; end
            qsg_pkg::QD_2: begin sin_o = -pos_dir; cos_o = -pos_mir; end
            default:       begin sin_o = -pos_mir; cos_o =  pos_dir; end
        endcase
    end
endmodule

// File: rtl/phase_quad_gen.sv
`timescale 1ns/1ps
module phase_quad_gen #(
    parameter int PH_W   = 24,
    parameter int ADDR_W = 10,
    parameter int SMP_W  = 16,
    parameter int FRAC_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PH_W-1:0]      ph_tdata,
    input  logic                 ph_tvalid,
    input  logic                 ph_tlast,
    input  logic                 ph_tuser,
    output logic                 ph_tready,
    output logic [2*SMP_W-1:0]   iq_tdata,
    output logic                 iq_tvalid,
    output logic                 iq_tlast,
    output logic                 iq_tuser,
    input  logic                 iq_tready
);
    localparam int LOW_W = PH_W - 2 - ADDR_W;
    localparam int MIR_W = ADDR_W + 1;
    localparam int UNIT  = 1 << FRAC_W;

    typedef struct packed {
        logic                     s1_vld;
        qsg_pkg::side_t           s1_side;
        qsg_pkg::quad_e           s1_quad;
        logic [ADDR_W-1:0]        s1_idx;
        logic                     s2_vld;
        qsg_pkg::side_t           s2_side;
        qsg_pkg::quad_e           s2_quad;
        logic [SMP_W-1:0]         s2_dir;
        logic [SMP_W-1:0]         s2_mir;
        logic                     o_vld;
        qsg_pkg::side_t           o_side;
        logic signed [SMP_W-1:0]  o_sin;
        logic signed [SMP_W-1:0]  o_cos;
    } pipe_t;

    pipe_t st_d, st_q;

    logic                    beat_in;
    logic [MIR_W-1:0]        addr_dir;
    logic [MIR_W-1:0]        addr_mir;
    logic [SMP_W-1:0]        rom_dir;
    logic [SMP_W-1:0]        rom_mir;
    logic signed [SMP_W-1:0] fold_sin;
    logic signed [SMP_W-1:0] fold_cos;

    if (LOW_W > 0) begin : g_trunc
        logic unused_low_bits;
        assign unused_low_bits = ^ph_tdata[LOW_W-1:0];
    end

    assign addr_dir = {1'b0, st_q.s1_idx};
    assign addr_mir = (MIR_W'(1) << ADDR_W) - {1'b0, st_q.s1_idx};

    qsg_qtr_rom #(.ADDR_W(ADDR_W), .SMP_W(SMP_W), .FRAC_W(FRAC_W)) rom_i (
        .addr_a (addr_dir),
        .addr_b (addr_mir),
        .data_a (rom_dir),
        .data_b (rom_mir)
    );

    qsg_fold #(.SMP_W(SMP_W)) fold_i (
        .quad    (st_q.s2_quad),
        .mag_dir (st_q.s2_dir),
        .mag_mir (st_q.s2_mir),
        .sin_o   (fold_sin),
        .cos_o   (fold_cos)
    );

    assign ph_tready = !st_q.o_vld || iq_tready;
    assign beat_in   = ph_tvalid && ph_tready;

    always_comb begin
        st_d = st_q;
        if (beat_in) begin
            st_d.s1_vld  = 1'b1;
            st_d.s1_side = '{last: ph_tlast, user: ph_tuser};
            st_d.s1_quad = qsg_pkg::quad_e'(ph_tdata[PH_W-1 -: 2]);
            st_d.s1_idx  = ph_tdata[PH_W-3 -: ADDR_W];
            st_d.s2_vld  = st_q.s1_vld;
            st_d.s2_side = st_q.s1_side;
            st_d.s2_quad = st_q.s1_quad;
            st_d.s2_dir  = rom_dir;
            st_d.s2_mir  = rom_mir;
            st_d.o_vld   = st_q.s2_vld;
            st_d.o_side  = st_q.s2_side;
            st_d.o_sin   = fold_sin;
            st_d.o_cos   = fold_cos;
        end else if (iq_tready) begin
            st_d.o_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iq_tdata  = {st_q.o_sin, st_q.o_cos};
    assign iq_tvalid = st_q.o_vld;
    assign iq_tlast  = st_q.o_side.last;
    assign iq_tuser  = st_q.o_side.user;

    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> !iq_tvalid);

    p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iq_tvalid && !iq_tready |=> iq_tvalid && $stable(iq_tdata)
                                    && $stable(iq_tlast) && $stable(iq_tuser));

    p_no_input_no_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_tvalid && ph_tready) && !iq_tvalid |=> !iq_tvalid);

    p_no_input_same_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_tvalid && ph_tready) |=> $stable(iq_tdata));

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iq_tvalid |-> ($signed(iq_tdata[2*SMP_W-1:SMP_W]) <= UNIT)
                   && ($signed(iq_tdata[2*SMP_W-1:SMP_W]) >= -UNIT)
                   && ($signed(iq_tdata[SMP_W-1:0]) <= UNIT)
                   && ($signed(iq_tdata[SMP_W-1:0]) >= -UNIT));
endmodule

// File: tb/phase_quad_gen_tb_top.sv
`timescale 1ns/1ps
module phase_quad_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] ph_tdata = '0;
    logic        ph_tvalid = 1'b0;
    logic        ph_tlast = 1'b0;
    logic        ph_tuser = 1'b0;
    logic        ph_tready;
    logic [31:0] iq_tdata;
    logic        iq_tvalid;
    logic        iq_tlast;
    logic        iq_tuser;
    logic        iq_tready = 1'b0;

    always #10 clk = ~clk;

    phase_quad_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .ph_tdata(ph_tdata), .ph_tvalid(ph_tvalid), .ph_tlast(ph_tlast),
        .ph_tuser(ph_tuser), .ph_tready(ph_tready),
        .iq_tdata(iq_tdata), .iq_tvalid(iq_tvalid), .iq_tlast(iq_tlast),
        .iq_tuser(iq_tuser), .iq_tready(iq_tready)
    );

    typedef struct {
        logic [23:0] ph;
        bit          l;
        bit          u;
    } beat_t;

    beat_t       pend[$];
    beat_t       cur;
    bit          m_vld = 1'b0;
    bit          prev_acc = 1'b0;
    logic [31:0] prev_data = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int          pt;
        real         ang, es, ec;
        logic signed [15:0] ds, dc;
        chk(iq_tvalid == m_vld, "R5", "iq_tvalid", iq_tvalid, m_vld);
        if (!prev_acc)
            chk(iq_tdata == prev_data, "R5", "word stable without input", iq_tdata, prev_data);
        if (m_vld) begin
            pt  = int'(cur.ph >> 12);
            ang = 2.0 * 3.141592653589793 * pt / 4096.0;
            es  = $sin(ang) * 16384.0;
            ec  = $cos(ang) * 16384.0;
            ds  = iq_tdata[31:16];
            dc  = iq_tdata[15:0];
            chk((ds - es) <= 2.0 && (ds - es) >= -2.0,
                (cur.ph[11:0] != 0) ? "R1 R2 R3" : "R2 R3", "sine bits 31:16", ds, longint'($rtoi(es)));
            chk((dc - ec) <= 2.0 && (dc - ec) >= -2.0,
                (cur.ph[11:0] != 0) ? "R1 R2 R3" : "R2 R3", "cosine bits 15:0", dc, longint'($rtoi(ec)));
            if (pt % 1024 == 0) begin
                chk(ds == $rtoi(es + ((es < 0) ? -0.5 : 0.5)), "R8", "exact sine", ds, longint'($rtoi(es)));
                chk(dc == $rtoi(ec + ((ec < 0) ? -0.5 : 0.5)), "R8", "exact cosine", dc, longint'($rtoi(ec)));
            end
            chk(iq_tlast == cur.l, "R4", "last flag", iq_tlast, cur.l);
            chk(iq_tuser == cur.u, "R4", "user flag", iq_tuser, cur.u);
        end
    endtask

    task automatic step(input bit v, input logic [23:0] ph, input bit l, input bit u, input bit r);
        bit acc;
        beat_t b;
        @(negedge clk);
        compare();
        ph_tvalid = v; ph_tdata = ph; ph_tlast = l; ph_tuser = u; iq_tready = r;
        #1;
        chk(ph_tready == (!m_vld || r), "R6", "ph_tready", ph_tready, !m_vld || r);
        prev_data = iq_tdata;
        acc = v && (!m_vld || r);
        prev_acc = acc;
        if (acc) begin
            b.ph = ph; b.l = l; b.u = u;
            pend.push_back(b);
            if (pend.size() == 3) begin
                cur = pend.pop_front();
                m_vld = 1'b1;
            end else begin
                m_vld = 1'b0;
            end
        end else if (r) begin
            m_vld = 1'b0;
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        ph_tvalid = 1'b0;
        pend.delete();
        m_vld = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(iq_tvalid == 1'b0, "R7", "iq_tvalid in reset", iq_tvalid, 0);
        end
        rst_n = 1'b1;
        prev_acc = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(3);
        // R7: first cycle after reset shows nothing
        step(1'b0, 24'h0, 1'b0, 1'b0, 1'b1);

        // R8 / R1: quadrant points, then phases with low bits set
        step(1'b1, 24'h000000, 1'b0, 1'b1, 1'b1);
        step(1'b1, 24'h400000, 1'b1, 1'b0, 1'b1);
        step(1'b1, 24'h800000, 1'b0, 1'b0, 1'b1);
        step(1'b1, 24'hC00000, 1'b1, 1'b1, 1'b1);
        step(1'b1, 24'h000FFF, 1'b0, 1'b1, 1'b1);
        step(1'b1, 24'h3FFFFF, 1'b1, 1'b0, 1'b1);
        step(1'b1, 24'h555AAA, 1'b0, 1'b0, 1'b1);
        // R5: input stops, last results stay inside
        for (int i = 0; i < 6; i++) step(1'b0, 24'h0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 24'h123456, 1'b1, 1'b1, 1'b1);
        step(1'b1, 24'hFEDCBA, 1'b0, 1'b1, 1'b1);

        // R7: reset with beats in flight discards them
        step(1'b1, 24'h200000, 1'b1, 1'b1, 1'b1);
        do_reset(2);
        step(1'b1, 24'h600000, 1'b0, 1'b0, 1'b1);
        step(1'b1, 24'hA00000, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 24'h0, 1'b0, 1'b0, 1'b1);

        // R6: backpressure with continuous input
        for (int i = 0; i < 40; i++)
            step(1'b1, 24'(i * 24'h06A3C5), i[0], i[1], (i % 5) == 4);

        // random phases, flags, gaps and backpressure
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, 24'($urandom), 1'($urandom), 1'($urandom), ($urandom % 3) != 0);

        // R5/R6: stop input while the output side stalls, then drain
        for (int i = 0; i < 8; i++) step(1'b0, 24'h0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 24'h0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 24'h0, 1'b0, 1'b0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule